// File: doc/BRIEF.md
# Half-Bridge Gate Enable Interlock

This block is the synchronous control logic for one leg of a power half-bridge. It turns a high-side command (active high) and a low-side command (active low) into two gate enables. It refuses any request that would make both switches conduct together. It keeps both switches off for a programmable number of clock cycles at every hand-over from one switch to the other.

An active-low shutdown input and an overcurrent fault flag each force both gates off. An undervoltage lockout watches a digitized supply sample, given in millivolts with a valid strobe. The lockout uses hysteresis and holds the leg off while the supply is too low.

The two commands may be driven from one shared signal. In that case the leg alternates between its switches, and only the inserted dead time separates them. Both gate enables are registered, so every decision takes effect at the first clock edge that samples it.

Top module: `hbi_leg_ctrl`

## Requirements
- R1: After reset both gate enables are low and the lockout is engaged. No gate turns on, whatever the commands, until a valid supply sample has released the lockout.
- R2: With shutdown high, no fault and the lockout released, `hi_cmd`=1 together with `lo_cmd_n`=1 requests the high side. `hs_gate` then rises once the dead-time rule allows it, and `ls_gate` stays low.
- R3: Under the same conditions, `hi_cmd`=0 together with `lo_cmd_n`=0 requests the low side. `ls_gate` rises once the dead-time rule allows it, and `hs_gate` stays low.
- R4: `hi_cmd`=1 together with `lo_cmd_n`=0 is a conflict. Both enables are low from the first clock edge that samples it, and they stay low for as long as it lasts.
- R5: `hi_cmd`=0 together with `lo_cmd_n`=1 requests neither switch, and both enables are low.
- R6: While `shdn_n` is 0, both enables are low from the first clock edge that samples it, regardless of the commands.
- R7: While `fault` is 1, both enables are low from the first clock edge that samples it, regardless of the commands.
- R8: When one enable falls at clock edge t, the opposite enable cannot rise before edge t+DEAD_CYC. If the opposite side is requested immediately, it rises exactly at t+DEAD_CYC. This holds in both directions, including when both commands come from one shared signal.
- R9: A request for the opposite side that arrives inside the dead window is still delayed until edge t+DEAD_CYC.
- R10: If both enables have been low for at least DEAD_CYC cycles, a new request turns its gate on at the first clock edge that samples it.
- R11: A valid sample strictly above UV_ON_MV (12000) releases the lockout, and a valid sample strictly below UV_OFF_MV (10500) engages it. A sample in between, or equal to either threshold, leaves the lockout unchanged.
- R12: The lockout state changes only on a cycle with `vsup_vld`=1. Sample values presented with `vsup_vld`=0 have no effect.
- R13: An engaged lockout drives both enables low one edge after it engages. After it releases at edge e, no gate rises before edge e+DEAD_CYC.
- R14: `hs_gate` and `ls_gate` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd | input | 1 | High-side command, active high |
| lo_cmd_n | input | 1 | Low-side command, active low |
| shdn_n | input | 1 | Shutdown, active low |
| fault | input | 1 | Overcurrent or overtemperature flag, active high |
| vsup_mv | input | VW (16) | Supply voltage sample in millivolts, unsigned |
| vsup_vld | input | 1 | Strobe qualifying `vsup_mv` |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
Four command patterns are applied to the decode: high only, low only, the conflict pattern and the idle pattern. Together they show that the active-low polarity of the low-side input is honoured and that a conflict is not passed through as either side. Hand-overs are timed for three cases: an immediate hand-over in each direction (once with both commands tied together), a request arriving a few cycles into the dead window, and a request after a long idle period. These cases separate a counter measured from the falling gate from one measured from the request. Supply samples at, just above and just below both thresholds, plus samples held without a strobe, separate the hysteresis band from the comparison edges.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   // Pair of gate enables for one half-bridge leg
   typedef struct packed {
      logic hs;
      logic ls;
   } gate_pair_t;

endpackage

// File: rtl/hbi_uvlo.sv
module hbi_uvlo #(
   parameter int VW        = 16,
   parameter int UV_ON_MV  = 12000,
   parameter int UV_OFF_MV = 10500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vsup_mv,
   input  logic          vsup_vld,
   output logic          locked
);

   localparam logic [VW-1:0] ON_CODE  = VW'(UV_ON_MV);
   localparam logic [VW-1:0] OFF_CODE = VW'(UV_OFF_MV);

   initial begin : prm_chk
      assert (UV_OFF_MV < UV_ON_MV) else $error("lockout band inverted");
      assert (UV_ON_MV < (2 ** VW)) else $error("threshold exceeds sample width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (vsup_vld) begin
         if (locked && (vsup_mv > ON_CODE))
            locked <= 1'b0;
         else if (!locked && (vsup_mv < OFF_CODE))
            locked <= 1'b1;
      end
   end

   // R12
   uvlo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vsup_vld |=> $stable(locked));

   // R11
   uvlo_band_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsup_vld && locked && (vsup_mv <= ON_CODE)) |=> locked);

   // R11
   uvlo_band_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsup_vld && !locked && (vsup_mv >= OFF_CODE)) |=> !locked);

endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
   import hbi_pkg::*;
(
   input  logic       hi_cmd,
   input  logic       lo_cmd_n,
   input  logic       shdn_n,
   input  logic       fault,
   input  logic       locked,
   output gate_pair_t want
);

   logic leg_enable;

   always_comb begin
      leg_enable = shdn_n & ~fault & ~locked;
      // each side only when the other side is not requested
      want.hs    = leg_enable &  hi_cmd &  lo_cmd_n;
      want.ls    = leg_enable & ~hi_cmd & ~lo_cmd_n;
   end

endmodule

// File: rtl/hbi_deadtime.sv
module hbi_deadtime
   import hbi_pkg::*;
#(
   parameter int DEAD_CYC = 18
) (
   input  logic       clk,
   input  logic       rst_n,
   input  gate_pair_t want,
   input  logic       locked,
   output gate_pair_t gate
);

   localparam int LIM = DEAD_CYC - 1;
   localparam int CW  = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;

   initial begin : prm_chk
      assert (DEAD_CYC >= 1) else $error("dead time must be at least one cycle");
   end

   logic idle_ok;

   generate
      if (DEAD_CYC == 1) begin : g_single
         // one cycle with both gates low is the whole dead time
         assign idle_ok = 1'b1;
      end else begin : g_count
         logic [CW-1:0] idle_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idle_cnt <= '0;
            else if (gate.hs || gate.ls || locked)
               idle_cnt <= '0;
            else if (idle_cnt != CW'(LIM))
               idle_cnt <= idle_cnt + 1'b1;
         end

         assign idle_ok = (idle_cnt == CW'(LIM));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= '0;
      end else begin
         gate.hs <= want.hs & (gate.hs | (~gate.ls & idle_ok));
         gate.ls <= want.ls & (gate.ls | (~gate.hs & idle_ok));
      end
   end

   // R2 R3: a gate only rises on a request, after a cycle with both low
   rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate.hs) || $rose(gate.ls)) |-> $past(!gate.hs && !gate.ls));

endmodule

// File: rtl/hbi_leg_ctrl.sv
module hbi_leg_ctrl
   import hbi_pkg::*;
#(
   parameter int DEAD_CYC  = 18,
   parameter int VW        = 16,
   parameter int UV_ON_MV  = 12000,
   parameter int UV_OFF_MV = 10500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hi_cmd,
   input  logic          lo_cmd_n,
   input  logic          shdn_n,
   input  logic          fault,
   input  logic [VW-1:0] vsup_mv,
   input  logic          vsup_vld,
   output logic          hs_gate,
   output logic          ls_gate
);

   localparam int LW = $clog2(DEAD_CYC + 1);

   logic       locked;
   gate_pair_t want;
   gate_pair_t gate;

   hbi_uvlo #(
      .VW        (VW),
      .UV_ON_MV  (UV_ON_MV),
      .UV_OFF_MV (UV_OFF_MV)
   ) uvlo_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .vsup_mv  (vsup_mv),
      .vsup_vld (vsup_vld),
      .locked   (locked)
   );

   hbi_decode decode_i (
      .hi_cmd   (hi_cmd),
      .lo_cmd_n (lo_cmd_n),
      .shdn_n   (shdn_n),
      .fault    (fault),
      .locked   (locked),
      .want     (want)
   );

   hbi_deadtime #(
      .DEAD_CYC (DEAD_CYC)
   ) dead_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (want),
      .locked (locked),
      .gate   (gate)
   );

   assign hs_gate = gate.hs;
   assign ls_gate = gate.ls;

   // checker-side count of consecutive cycles with both gates low
   logic [LW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run <= '0;
      else if (hs_gate || ls_gate)
         low_run <= '0;
      else if (low_run != LW'(DEAD_CYC))
         low_run <= low_run + 1'b1;
   end

   // R14
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   // R8
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_gate) || $rose(ls_gate)) |-> (low_run >= LW'(DEAD_CYC)));

   // R6
   shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (!hs_gate && !ls_gate));

   // R7
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!hs_gate && !ls_gate));

   // R4
   conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cmd && !lo_cmd_n) |=> (!hs_gate && !ls_gate));

   // R5
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_cmd && lo_cmd_n) |=> (!hs_gate && !ls_gate));

   // R13
   lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (!hs_gate && !ls_gate));

endmodule

// File: tb/hbi_leg_ctrl_tb.sv
module hbi_leg_ctrl_tb_top;

   localparam int DEAD = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hi_cmd = 1'b0;
   logic        lo_cmd_n = 1'b1;
   logic        shdn_n = 1'b1;
   logic        fault = 1'b0;
   logic [15:0] vsup_mv = '0;
   logic        vsup_vld = 1'b0;
   logic        hs_gate;
   logic        ls_gate;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   bit  overlap_seen = 1'b0;

   always #5 clk = ~clk;

   hbi_leg_ctrl #(.DEAD_CYC(DEAD)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_cmd   (hi_cmd),
      .lo_cmd_n (lo_cmd_n),
      .shdn_n   (shdn_n),
      .fault    (fault),
      .vsup_mv  (vsup_mv),
      .vsup_vld (vsup_vld),
      .hs_gate  (hs_gate),
      .ls_gate  (ls_gate)
   );

   always @(negedge clk)
      if (rst_n && hs_gate && ls_gate) overlap_seen = 1'b1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_gates(input string req, input int hs_exp, input int ls_exp);
      chk({req, " hs"}, int'(hs_gate), hs_exp);
      chk({req, " ls"}, int'(ls_gate), ls_exp);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic h, input logic ln);
      hi_cmd   = h;
      lo_cmd_n = ln;
   endtask

   // applies one strobed sample; returns at the negedge after it is taken
   task automatic supply(input int mv);
      vsup_mv  = 16'(mv);
      vsup_vld = 1'b1;
      @(negedge clk);
      vsup_vld = 1'b0;
   endtask

   task automatic t_reset;
      drive(1'b1, 1'b1);
      tick(3);
      chk_gates("R1 in reset", 0, 0);
      rst_n = 1'b1;
      tick(DEAD + 4);
      chk_gates("R1 locked after reset", 0, 0);
   endtask

   task automatic t_release;
      supply(12000);
      tick(DEAD + 2);
      chk_gates("R11 equal to on threshold keeps lockout", 0, 0);
      supply(12001);
      tick(DEAD - 1);
      chk_gates("R13 dead time after release", 0, 0);
      tick(1);
      chk_gates("R2 high side on", 1, 0);
   endtask

   task automatic t_hand_hl;
      drive(1'b0, 1'b0);
      tick(1);
      chk_gates("R8 hs off first", 0, 0);
      tick(DEAD - 1);
      chk_gates("R8 ls held in dead window", 0, 0);
      tick(1);
      chk_gates("R3 low side on after dead time", 0, 1);
   endtask

   task automatic t_hand_tied;
      // both commands from one signal going high
      drive(1'b1, 1'b1);
      tick(1);
      chk_gates("R8 tied ls off first", 0, 0);
      tick(DEAD - 1);
      chk_gates("R8 tied hs held", 0, 0);
      tick(1);
      chk_gates("R8 tied hs on", 1, 0);
   endtask

   task automatic t_conflict_idle;
      drive(1'b1, 1'b0);
      tick(1);
      chk_gates("R4 conflict both off", 0, 0);
      tick(DEAD + 5);
      chk_gates("R4 conflict stays off", 0, 0);
      drive(1'b0, 1'b1);
      tick(3);
      chk_gates("R5 idle both off", 0, 0);
   endtask

   task automatic t_long_gap;
      drive(1'b1, 1'b1);
      tick(1);
      chk_gates("R10 direct turn-on after long gap", 1, 0);
   endtask

   task automatic t_short_gap;
      drive(1'b0, 1'b1);
      tick(3);
      drive(1'b0, 1'b0);
      tick(DEAD - 3);
      chk_gates("R9 request inside window held", 0, 0);
      tick(1);
      chk_gates("R9 on at end of window", 0, 1);
   endtask

   task automatic t_shutdown;
      shdn_n = 1'b0;
      tick(1);
      chk_gates("R6 shutdown forces off", 0, 0);
      drive(1'b1, 1'b1);
      tick(4);
      chk_gates("R6 commands ignored in shutdown", 0, 0);
      shdn_n = 1'b1;
      tick(DEAD + 1);
      chk_gates("R6 recovery after release", 1, 0);
   endtask

   task automatic t_fault;
      fault = 1'b1;
      tick(1);
      chk_gates("R7 fault forces off", 0, 0);
      drive(1'b0, 1'b0);
      tick(DEAD + 3);
      chk_gates("R7 commands ignored in fault", 0, 0);
      fault = 1'b0;
      tick(1);
      chk_gates("R10 direct low side after fault", 0, 1);
   endtask

   task automatic t_uvlo;
      supply(11000);
      tick(2);
      chk_gates("R11 inside band keeps running", 0, 1);
      supply(10500);
      tick(2);
      chk_gates("R11 equal to off threshold keeps running", 0, 1);
      vsup_mv = 16'd5000;
      tick(5);
      chk_gates("R12 unstrobed low sample ignored", 0, 1);
      supply(10499);
      chk_gates("R13 gate still on at engage edge", 0, 1);
      tick(1);
      chk_gates("R11 below off threshold locks", 0, 0);
      supply(11999);
      tick(DEAD + 3);
      chk_gates("R11 inside band stays locked", 0, 0);
      vsup_mv = 16'd15000;
      tick(DEAD + 3);
      chk_gates("R12 unstrobed high sample ignored", 0, 0);
      supply(12500);
      tick(DEAD - 1);
      chk_gates("R13 held after release", 0, 0);
      tick(1);
      chk_gates("R13 on after dead time", 0, 1);
   endtask

   initial begin
      tick(1);
      t_reset();
      t_release();
      t_hand_hl();
      t_hand_tied();
      t_conflict_idle();
      t_long_gap();
      t_short_gap();
      t_shutdown();
      t_fault();
      t_uvlo();
      chk("R14 no overlap seen", int'(overlap_seen), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule